// File: doc/BRIEF.md
# Register-Selectable NCO Control Core

This core is the digital heart of a direct digital synthesizer. It keeps a small bank of 32-bit tuning words and a bank of 12-bit phase offsets. Every clock, a 32-bit phase accumulator advances by the chosen tuning word. The top 12 bits of the accumulator, plus the chosen phase offset, leave the block as a phase word, together with a valid strobe. A waveform lookup and a converter downstream turn that word into an analog signal. The output frequency is the clock rate times the tuning word divided by 2^32. One offset step is 2π/4096.

Software drives the core with 16-bit command words. Bits 15:14 pick a command group. The other bits carry either a register address and a data byte, or control flags. The active tuning word and phase offset come either from three select pins or from bits held in a control register. An optional two-stage resynchronizer on the selection path adds two cycles of latency, and that latency is fixed and known. A hold-in-reset flag zeroes the accumulator and keeps every loaded register. A sleep flag freezes the accumulator. A clear flag sends the choice back to the pins and bypasses the resynchronizer.

Top module: `nco_ctrl_core`

## Requirements
- R1: While rst_n is low and after it rises, out_valid is 0 and phase_out is 0. The hold-in-reset flag starts at 1, and the resynchronizer and the bit-source flag start at 0. The output stays invalid until a command clears the hold-in-reset flag.
- R2: Let F be the active tuning word and P the active phase offset. Count the valid samples after leaving hold-in-reset from k = 0. Sample k equals bits 31:20 of ((k+1)·F mod 2^32), plus P, taken mod 4096.
- R3: With the resynchronizer off, a change on fsel_pin or psel_pin is first seen on phase_out at the 6th rising edge, counting the edge that samples the pin as the 1st.
- R4: With the resynchronizer on (command group 10, bit 13 = 1), the selection and write latencies of R3 and R7 become 8 edges.
- R5: A group 10 command sets bit 12 as the source flag. When bit 12 is 1, bit 11 chooses the tuning word and bits 10:9 choose the phase offset, and the pins are ignored.
- R6: A byte load uses bits 15:12 = 0011, an address in bits 11:8 and data in bits 7:0. Address 4n+b is byte b of tuning word n. Address 8+2m is the low byte of offset m, and address 9+2m holds its top nibble in data bits 3:0. Bytes other than the last byte of a register go only into a shared holding register. The destination register changes only when its last byte is written.
- R7: The write edge of the last byte into the active register counts as edge 1. The new value is first seen on phase_out at edge 6.
- R8: A group 11 command sets bit 12 as the hold-in-reset flag. While the flag is set, the accumulator is zero, out_valid is 0 and no register changes. After the flag is cleared, out_valid rises at the 6th edge, counting the write edge as the 1st.
- R9: A group 11 command sets bit 13 as the sleep flag. During sleep the accumulator holds its value and the output goes to 0 with out_valid low. After waking, the first valid sample is the last sample before sleep plus one tuning step.
- R10: Bit 11 = 1 in a group 11 command forces the resynchronizer flag and the source flag to 0. The pins then choose the registers again, with a latency of 6.
- R11: Group 01 commands, and group 00 commands whose bits 13:12 are not 11, change no register, including the holding register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Command word strobe, sampled on the rising edge |
| wr_word | input | 16 | Command word |
| fsel_pin | input | 1 | Tuning word select pin |
| psel_pin | input | 2 | Phase offset select pins |
| phase_out | output | 12 | Phase word sent to the lookup stage |
| out_valid | output | 1 | High when phase_out carries a running sample |

## Verification
Phase offsets are walked across all four select-pin codes with a zero tuning word. Each output value then names the register chosen, and the edge on which it changes measures the pipeline depth. The same switch is repeated through the control bits, with and without the resynchronizer, and after a clear. This tells the 6-edge and 8-edge paths apart and shows which source is in control. Four tuning words are tried: a unit step, an irregular value, half-scale and a negative unit step. Together they expose carry errors, truncation errors and wrap-around errors in the accumulator. Partial byte loads, ignored commands and a sleep/wake cycle each show whether hidden state was disturbed.

// File: rtl/nco_pkg.sv
package nco_pkg;
    localparam int ACC_W  = 32;
    localparam int PH_W   = 12;
    localparam int FREG_N = 2;
    localparam int PREG_N = 4;
    localparam int FSEL_W = $clog2(FREG_N);
    localparam int PSEL_W = $clog2(PREG_N);

    typedef enum logic [1:0] {
        GRP_DATA = 2'b00,
        GRP_NOP  = 2'b01,
        GRP_SEL  = 2'b10,
        GRP_PWR  = 2'b11
    } cmd_grp_e;

    typedef struct packed {
        logic             hold_rst;
        logic             sleep;
        logic [ACC_W-1:0] fw;
        logic [PH_W-1:0]  pw;
    } nco_sel_t;

    localparam nco_sel_t SEL_RST = '{hold_rst: 1'b1, sleep: 1'b0, fw: '0, pw: '0};
endpackage

// File: rtl/nco_regbank.sv
module nco_regbank
    import nco_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [15:0]       wr_word,
    input  logic              fsel_pin,
    input  logic [PSEL_W-1:0] psel_pin,
    output nco_sel_t          sel_o,
    output logic              sync_o
);
    localparam int HOLD_W = ACC_W - 8;

    typedef struct packed {
        logic [FREG_N-1:0][ACC_W-1:0] freg;
        logic [PREG_N-1:0][PH_W-1:0]  preg;
        logic [HOLD_W-1:0]            hold;
        logic                         sync_en;
        logic                         src_bits;
        logic [FSEL_W-1:0]            fsel_bit;
        logic [PSEL_W-1:0]            psel_bits;
        logic                         sleep;
        logic                         hold_rst;
        logic [FSEL_W-1:0]            fpin;
        logic [PSEL_W-1:0]            ppin;
    } bank_t;

    bank_t bank_d, bank_q;
    cmd_grp_e grp;
    logic [3:0] addr;
    logic [7:0] data;
    logic [FSEL_W-1:0] fidx, fs;
    logic [PSEL_W-1:0] pidx, ps;

    always_comb begin
        grp  = cmd_grp_e'(wr_word[15:14]);
        addr = wr_word[11:8];
        data = wr_word[7:0];
        fidx = addr[2 +: FSEL_W];
        pidx = addr[1 +: PSEL_W];
        bank_d      = bank_q;
        bank_d.fpin = fsel_pin;
        bank_d.ppin = psel_pin;
        if (wr_en) begin
            case (grp)
                GRP_DATA: begin
                    if (wr_word[13:12] == 2'b11) begin
                        if (!addr[3]) begin
                            if (addr[1:0] == 2'b11)
                                bank_d.freg[fidx] = {data, bank_q.hold};
                            else
                                bank_d.hold[{addr[1:0], 3'b000} +: 8] = data;
                        end else begin
                            if (addr[0])
                                bank_d.preg[pidx] = {data[PH_W-9:0], bank_q.hold[7:0]};
                            else
                                bank_d.hold[7:0] = data;
                        end
                    end
                end
                GRP_SEL: begin
                    bank_d.sync_en   = wr_word[13];
                    bank_d.src_bits  = wr_word[12];
                    bank_d.fsel_bit  = wr_word[11 -: FSEL_W];
                    bank_d.psel_bits = wr_word[10 -: PSEL_W];
                end
                GRP_PWR: begin
                    bank_d.sleep    = wr_word[13];
                    bank_d.hold_rst = wr_word[12];
                    if (wr_word[11]) begin
                        bank_d.sync_en  = 1'b0;
                        bank_d.src_bits = 1'b0;
                    end
                end
                default: ;
            endcase
        end
        fs = bank_q.src_bits ? bank_q.fsel_bit  : bank_q.fpin;
        ps = bank_q.src_bits ? bank_q.psel_bits : bank_q.ppin;
        sel_o.hold_rst = bank_q.hold_rst;
        sel_o.sleep    = bank_q.sleep;
        sel_o.fw       = bank_q.freg[fs];
        sel_o.pw       = bank_q.preg[ps];
        sync_o         = bank_q.sync_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q          <= '0;
            bank_q.hold_rst <= 1'b1;
        end else begin
            bank_q <= bank_d;
        end
    end

    // R10
    clear_to_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_word[15:14] == 2'b11 && wr_word[11]) |=> (!sync_o && !bank_q.src_bits));

    // R6
    partial_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_word[15:12] == 4'b0011 && !wr_word[11] && wr_word[9:8] != 2'b11)
        |=> $stable(bank_q.freg));

    // R11
    ignored_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_word[15:14] == 2'b01 || (wr_word[15:14] == 2'b00 && wr_word[13:12] != 2'b11)))
        |=> ($stable(bank_q.freg) && $stable(bank_q.preg) && $stable(bank_q.hold) && $stable(sync_o)));
endmodule

// File: rtl/nco_sync_delay.sv
module nco_sync_delay
    import nco_pkg::*;
#(
    parameter int SYNC_N = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  nco_sel_t sel_i,
    input  logic     sync_en_i,
    output nco_sel_t sel_o
);
    nco_sel_t s2_d, s2_q;

    always_comb s2_d = sel_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s2_q <= SEL_RST;
        else        s2_q <= s2_d;
    end

    generate
        if (SYNC_N > 0) begin : g_sync
            nco_sel_t chain_d [SYNC_N];
            nco_sel_t chain_q [SYNC_N];

            always_comb begin
                chain_d[0] = s2_q;
                for (int i = 1; i < SYNC_N; i++) chain_d[i] = chain_q[i-1];
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    for (int i = 0; i < SYNC_N; i++) chain_q[i] <= SEL_RST;
                end else begin
                    for (int i = 0; i < SYNC_N; i++) chain_q[i] <= chain_d[i];
                end
            end

            assign sel_o = sync_en_i ? chain_q[SYNC_N-1] : s2_q;
        end else begin : g_bypass
            assign sel_o = s2_q;
        end
    endgenerate
endmodule

// File: rtl/nco_phase_path.sv
module nco_phase_path
    import nco_pkg::*;
#(
    parameter int OUT_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  nco_sel_t        sel_i,
    output logic [PH_W-1:0] phase_o,
    output logic            valid_o
);
    typedef struct packed {
        logic [ACC_W-1:0]                 acc;
        logic [PH_W-1:0]                  pw;
        logic                             run;
        logic [PH_W-1:0]                  sum;
        logic                             sum_v;
        logic [OUT_STAGES-1:0][PH_W-1:0]  ow;
        logic [OUT_STAGES-1:0]            ov;
    } path_t;

    path_t path_d, path_q;

    always_comb begin
        path_d = path_q;
        if (sel_i.hold_rst)   path_d.acc = '0;
        else if (sel_i.sleep) path_d.acc = path_q.acc;
        else                  path_d.acc = path_q.acc + sel_i.fw;
        path_d.pw    = sel_i.pw;
        path_d.run   = !sel_i.hold_rst && !sel_i.sleep;
        path_d.sum   = path_q.run ? (path_q.acc[ACC_W-1 -: PH_W] + path_q.pw) : '0;
        path_d.sum_v = path_q.run;
        path_d.ow[0] = path_q.sum;
        path_d.ov[0] = path_q.sum_v;
        for (int i = 1; i < OUT_STAGES; i++) begin
            path_d.ow[i] = path_q.ow[i-1];
            path_d.ov[i] = path_q.ov[i-1];
        end
        phase_o = path_q.ow[OUT_STAGES-1];
        valid_o = path_q.ov[OUT_STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) path_q <= '0;
        else        path_q <= path_d;
    end

    // R8
    acc_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_i.hold_rst |=> (path_q.acc == '0));

    // R9
    sleep_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i.sleep && !sel_i.hold_rst) |=> $stable(path_q.acc));

    // R1
    idle_output_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> (phase_o == '0));
endmodule

// File: rtl/nco_ctrl_core.sv
module nco_ctrl_core
    import nco_pkg::*;
#(
    parameter int SYNC_N     = 2,
    parameter int OUT_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [15:0]       wr_word,
    input  logic              fsel_pin,
    input  logic [PSEL_W-1:0] psel_pin,
    output logic [PH_W-1:0]   phase_out,
    output logic              out_valid
);
    nco_sel_t sel_raw, sel_late;
    logic     sync_en;

    nco_regbank u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_word  (wr_word),
        .fsel_pin (fsel_pin),
        .psel_pin (psel_pin),
        .sel_o    (sel_raw),
        .sync_o   (sync_en)
    );

    nco_sync_delay #(.SYNC_N(SYNC_N)) u_delay (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_i     (sel_raw),
        .sync_en_i (sync_en),
        .sel_o     (sel_late)
    );

    nco_phase_path #(.OUT_STAGES(OUT_STAGES)) u_path (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_i   (sel_late),
        .phase_o (phase_out),
        .valid_o (out_valid)
    );
endmodule

// File: tb/tb_nco_ctrl_core.sv
module tb_nco_ctrl_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_word = '0;
    logic        fsel_pin = 1'b0;
    logic [1:0]  psel_pin = '0;
    logic [11:0] phase_out;
    logic        out_valid;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    always #5 clk = ~clk;

    nco_ctrl_core dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_word(wr_word),
        .fsel_pin(fsel_pin), .psel_pin(psel_pin),
        .phase_out(phase_out), .out_valid(out_valid)
    );

    // pin code, expected phase offset shown with a zero tuning word
    localparam logic [13:0] PIN_VEC [4] = '{
        {2'd2, 12'h333}, {2'd3, 12'hABC}, {2'd1, 12'h222}, {2'd0, 12'h111}
    };
    localparam logic [31:0] FLIST [4] = '{
        32'h0010_0000, 32'h0123_4567, 32'h8000_0000, 32'hFFF0_0000
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] bw(input logic [3:0] a, input logic [7:0] d);
        return {4'b0011, a, d};
    endfunction
    function automatic logic [15:0] ctl(input bit s, input bit r, input bit c);
        return {2'b11, s, r, c, 11'b0};
    endfunction
    function automatic logic [15:0] selw(input bit sy, input bit src, input bit fb, input logic [1:0] pb);
        return {2'b10, sy, src, fb, pb, 9'b0};
    endfunction
    function automatic logic [11:0] expf(input logic [31:0] f, input int k, input logic [11:0] p);
        logic [31:0] m;
        m = f * 32'(k + 1);
        return m[31:20] + p;
    endfunction

    task automatic wr(input logic [15:0] w);
        @(negedge clk); wr_en = 1'b1; wr_word = w;
        @(negedge clk); wr_en = 1'b0; wr_word = '0;
    endtask
    task automatic setpins(input bit f, input logic [1:0] p);
        @(negedge clk); fsel_pin = f; psel_pin = p;
        @(negedge clk);
    endtask
    task automatic loadf(input int n, input logic [31:0] v);
        for (int b = 0; b < 4; b++) wr(bw(4'(4*n + b), v[8*b +: 8]));
    endtask
    task automatic loadp(input int m, input logic [11:0] v);
        wr(bw(4'(8 + 2*m), v[7:0]));
        wr(bw(4'(9 + 2*m), {4'h0, v[11:8]}));
    endtask
    task automatic switch_at(input int lat, input logic [11:0] oldv, input logic [11:0] newv, input string req);
        repeat (lat - 2) @(negedge clk);
        chk(phase_out == oldv, req, phase_out, oldv);
        @(negedge clk);
        chk(phase_out == newv, req, phase_out, newv);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog R1 actual=0x0 expected=0x1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [11:0] last;
        last = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!out_valid, "R1", out_valid, 0);
        chk(phase_out == 12'h0, "R1", phase_out, 0);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        chk(!out_valid, "R1", out_valid, 0);

        loadp(0, 12'h111); loadp(1, 12'h222); loadp(2, 12'h333); loadp(3, 12'hABC);
        repeat (10) @(negedge clk);
        chk(!out_valid && phase_out == 0, "R8", out_valid, 0);
        // R8: release the hold-in-reset flag, valid at edge 6
        wr(ctl(0, 0, 0));
        repeat (4) @(negedge clk);
        chk(!out_valid, "R8", out_valid, 0);
        @(negedge clk);
        chk(out_valid && phase_out == 12'h111, "R8", phase_out, 12'h111);

        // R3: pin table walk, latency 6
        for (int i = 0; i < 4; i++) begin
            logic [11:0] prev;
            prev = phase_out;
            setpins(1'b0, PIN_VEC[i][13:12]);
            switch_at(6, prev, PIN_VEC[i][11:0], "R3");
        end

        // R5: bits take over the choice
        wr(selw(0, 1, 0, 2'b11));
        switch_at(6, 12'h111, 12'hABC, "R5");
        setpins(1'b0, 2'b01);
        repeat (10) @(negedge clk);
        chk(phase_out == 12'hABC, "R5", phase_out, 12'hABC);
        setpins(1'b0, 2'b00);

        // R4: resynchronizer adds two edges
        wr(selw(1, 1, 0, 2'b01));
        switch_at(8, 12'hABC, 12'h222, "R4");
        wr(selw(1, 1, 0, 2'b10));
        switch_at(8, 12'h222, 12'h333, "R4");
        // R7 with R4: write into the active offset
        loadp(2, 12'h3C5);
        switch_at(8, 12'h333, 12'h3C5, "R7");

        // R10: clear returns control to the pins, latency 6
        wr(ctl(0, 0, 1));
        switch_at(6, 12'h3C5, 12'h111, "R10");

        // R6: a low byte alone leaves the offset untouched
        wr(bw(4'h8, 8'h55));
        repeat (10) @(negedge clk);
        chk(phase_out == 12'h111, "R6", phase_out, 12'h111);
        wr(bw(4'h9, 8'h06));
        switch_at(6, 12'h111, 12'h655, "R7");

        // R11: ignored command groups
        wr({2'b01, 2'b11, 4'h9, 8'hFF});
        wr({2'b00, 2'b10, 4'h8, 8'hAA});
        wr({2'b00, 2'b01, 4'h9, 8'h0F});
        repeat (10) @(negedge clk);
        chk(phase_out == 12'h655, "R11", phase_out, 12'h655);
        wr(bw(4'h9, 8'h07));
        switch_at(6, 12'h655, 12'h755, "R11");

        // R2: accumulation for several tuning words via fsel pin = 1
        for (int j = 0; j < 4; j++) begin
            wr(ctl(0, 1, 0));
            setpins(1'b1, 2'b00);
            loadf(1, FLIST[j]);
            repeat (10) @(negedge clk);
            chk(!out_valid && phase_out == 0, "R8", phase_out, 0);
            wr(ctl(0, 0, 0));
            repeat (4) @(negedge clk);
            chk(!out_valid, "R8", out_valid, 0);
            for (int k = 0; k < 6; k++) begin
                @(negedge clk);
                chk(out_valid && phase_out == expf(FLIST[j], k, 12'h755), "R2",
                    phase_out, expf(FLIST[j], k, 12'h755));
            end
        end

        // R9: sleep freezes, wake continues one step on (step is -1)
        wr(ctl(1, 0, 0));
        for (int t = 0; t < 20; t++) begin
            @(negedge clk);
            if (!out_valid) break;
            last = phase_out;
        end
        repeat (10) @(negedge clk);
        chk(!out_valid && phase_out == 0, "R9", phase_out, 0);
        wr(ctl(0, 0, 0));
        for (int t = 0; t < 20; t++) begin
            @(negedge clk);
            if (out_valid) break;
        end
        chk(out_valid && phase_out == last + 12'hFFF, "R9", phase_out, last + 12'hFFF);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule